// File: doc/BRIEF.md
# Twisted-Pair Receive Squelch Qualifier

This block decides when a 10 Mb/s twisted-pair receiver is carrying real data rather than impulse noise. Its two inputs are comparator flags that the analog front end has already digitized and synchronized. One flag reports an excursion above the positive squelch threshold and the other reports an excursion below the negative one. The block accepts a packet only after the flags alternate in polarity within a short time window. It then holds a data-valid output until the line has been quiet for longer than that window.

While data is valid, the block also drives a select output. This output tells the front end to use its reduced thresholds, so that noise in the middle of a packet is less likely to end the packet early. The qualification step uses up roughly the first three preamble bits of each packet. Downstream logic accepts this loss, and the block makes no attempt to recover those bits.

The block behaves the same way whether the link runs half or full duplex. All timing is counted in clock cycles of the sampling clock. The window length is the parameter `WIN_CYC`. A 150 ns window sampled at 20 MHz is 3 cycles. Both outputs are level signals with no back-pressure. They are plain control pins rather than a valid/ready stream, because the block carries no data payload.

Top module: `sqq_squelch_qualifier`

## Requirements
- R1: After reset, `data_valid` and `low_thresh_sel` are 0 and the qualifier is idle.
- R2: While idle and not valid, a cycle with either flag high starts an attempt and records that flag's polarity as the original polarity. If both flags are high in that cycle, positive is taken as the original polarity.
- R3: After the starting cycle, the opposite-polarity flag must be sampled high at some offset of 1 to `WIN_CYC` cycles. If it is not, the attempt is rejected and `data_valid` stays 0.
- R4: After the opposite crossing, the original-polarity flag must be sampled high at an offset of 1 to `WIN_CYC` cycles. When it is, `data_valid` is 1 from the clock edge that samples that crossing, and the sequencer returns to idle.
- R5: While valid, a run of up to `WIN_CYC` consecutive cycles with both flags low keeps `data_valid` at 1. On the edge that samples the (`WIN_CYC`+1)-th consecutive quiet cycle, `data_valid` drops to 0.
- R6: `low_thresh_sel` equals `data_valid` in every cycle. It rises and falls on the same edges.
- R7: After a rejection, the flags are ignored until a cycle in which both flags are sampled low. A flag held high through a rejection therefore cannot start a new attempt.
- R8: While an attempt waits for a crossing, crossings of the polarity it is not waiting for are ignored. In particular, they do not restart the window.
- R9: In the cycle after `data_valid` falls, the block is idle again and can qualify a new packet at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_hit | input | 1 | Positive squelch-threshold excursion flag |
| neg_hit | input | 1 | Negative squelch-threshold excursion flag |
| data_valid | output | 1 | Receive data is considered present |
| low_thresh_sel | output | 1 | Selects the reduced squelch thresholds |

## Verification
The assertions assume that the comparator flags are already synchronous to `clk` and change only between edges. They also assume that any pattern of the two flags is legal, including both high at once. The bench drives the flags just after the falling edge and samples the outputs just after the rising edge. The bench sweeps both gap offsets of the three-crossing sequence from 1 to `WIN_CYC`+2 for both starting polarities. It also drives quiet gaps on either side of the end-of-packet limit, and flags held high across a rejection.

// File: rtl/sqq_pkg.sv
package sqq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE      = 2'd0,
    SQ_WAIT_OPP  = 2'd1,
    SQ_WAIT_ORIG = 2'd2,
    SQ_LOCK      = 2'd3
  } sq_state_t;

  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } sq_pol_t;
endpackage

// File: rtl/sqq_window_timer.sv
module sqq_window_timer #(
  parameter int LIMIT = 3,
  localparam int CW = $clog2(LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CAP = CW'(LIMIT + 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (en && count != CAP) count <= count + 1'b1;
  end
endmodule

// File: rtl/sqq_seq_fsm.sv
module sqq_seq_fsm
  import sqq_pkg::*;
#(
  parameter int WIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_hit,
  input  logic neg_hit,
  input  logic busy,
  output logic qualify
);
  localparam int CW = $clog2(WIN_CYC + 2);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  sq_state_t state, state_n;
  sq_pol_t   orig, orig_n;
  logic [CW-1:0] tcount;
  logic orig_hit, opp_hit, win_last, tclr, ten;

  assign orig_hit = (orig == POL_POS) ? pos_hit : neg_hit;
  assign opp_hit  = (orig == POL_POS) ? neg_hit : pos_hit;
  assign win_last = (tcount == LAST);

  always_comb begin
    state_n = state;
    orig_n  = orig;
    qualify = 1'b0;
    unique case (state)
      SQ_IDLE: if (!busy && (pos_hit || neg_hit)) begin
        state_n = SQ_WAIT_OPP;
        orig_n  = pos_hit ? POL_POS : POL_NEG;
      end
      SQ_WAIT_OPP: begin
        if (opp_hit)       state_n = SQ_WAIT_ORIG;
        else if (win_last) state_n = SQ_LOCK;
      end
      SQ_WAIT_ORIG: begin
        if (orig_hit) begin
          state_n = SQ_IDLE;
          qualify = 1'b1;
        end else if (win_last) state_n = SQ_LOCK;
      end
      SQ_LOCK: if (!pos_hit && !neg_hit) state_n = SQ_IDLE;
      default: state_n = SQ_IDLE;
    endcase
  end

  assign tclr = (state_n != state) &&
                (state_n == SQ_WAIT_OPP || state_n == SQ_WAIT_ORIG);
  assign ten  = (state == SQ_WAIT_OPP || state == SQ_WAIT_ORIG);

  sqq_window_timer #(.LIMIT(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(tclr), .en(ten), .count(tcount)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      orig  <= POL_POS;
    end else begin
      state <= state_n;
      orig  <= orig_n;
    end
  end

  // R3: a waiting step never outlives its window
  p_win_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT_OPP || state == SQ_WAIT_ORIG) |-> (tcount < CW'(WIN_CYC)));

  // R7: any flag high keeps the lockout in place
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_LOCK && (pos_hit || neg_hit)) |=> (state == SQ_LOCK));

  // R4: the sequencer sits idle while data is valid
  p_idle_when_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state == SQ_IDLE));
endmodule

// File: rtl/sqq_pkt_tracker.sv
module sqq_pkt_tracker #(
  parameter int WIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qualify,
  input  logic pos_hit,
  input  logic neg_hit,
  output logic data_valid,
  output logic low_sel
);
  localparam int CW = $clog2(WIN_CYC + 2);

  logic [CW-1:0] gap;
  logic any_hit, eop;

  assign any_hit = pos_hit || neg_hit;
  assign eop     = data_valid && !any_hit && (gap == CW'(WIN_CYC));

  sqq_window_timer #(.LIMIT(WIN_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(qualify || any_hit),
    .en(data_valid && !any_hit), .count(gap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_valid <= 1'b0;
      low_sel    <= 1'b0;
    end else begin
      if (qualify) data_valid <= 1'b1;
      else if (eop) data_valid <= 1'b0;
      if (qualify) low_sel <= 1'b1;
      else if (eop) low_sel <= 1'b0;
    end
  end

  // R6: reduced-threshold select follows validity
  p_sel_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid == low_sel);

  // R4: validity only rises on a completed sequence
  p_rise_on_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(qualify));

  // R5: validity only falls after a full quiet window
  p_fall_after_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> ($past(gap) == CW'(WIN_CYC) && !$past(any_hit)));
endmodule

// File: rtl/sqq_squelch_qualifier.sv
module sqq_squelch_qualifier #(
  parameter int WIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_hit,
  input  logic neg_hit,
  output logic data_valid,
  output logic low_thresh_sel
);
  logic qualify;

  sqq_seq_fsm #(.WIN_CYC(WIN_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pos_hit(pos_hit), .neg_hit(neg_hit),
    .busy(data_valid), .qualify(qualify)
  );

  sqq_pkt_tracker #(.WIN_CYC(WIN_CYC)) u_trk (
    .clk(clk), .rst_n(rst_n), .qualify(qualify), .pos_hit(pos_hit),
    .neg_hit(neg_hit), .data_valid(data_valid), .low_sel(low_thresh_sel)
  );
endmodule

// File: tb/sqq_squelch_qualifier_test.sv
module sqq_squelch_qualifier_test;
  localparam int WIN = 3;

  logic clk = 1'b0, rst_n = 1'b0, pos_hit = 1'b0, neg_hit = 1'b0;
  logic data_valid, low_thresh_sel;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sqq_squelch_qualifier #(.WIN_CYC(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .pos_hit(pos_hit), .neg_hit(neg_hit),
    .data_valid(data_valid), .low_thresh_sel(low_thresh_sel)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (data_valid !== exp || low_thresh_sel !== exp) begin
      n_bad++;
      $display("FAIL %s: data_valid=%b low_thresh_sel=%b expected %b at %0t",
               req, data_valid, low_thresh_sel, exp, $time);
    end
  endtask

  task automatic step(input logic p, input logic n, input logic exp, input string req);
    @(negedge clk);
    pos_hit = p;
    neg_hit = n;
    @(posedge clk);
    #2;
    check(exp, req);
  endtask

  task automatic flush(input string req);
    for (int k = 0; k < 2 * WIN + 4; k++) step(1'b0, 1'b0, 1'b0, req);
  endtask

  // drain after a valid packet: WIN quiet cycles stay valid, next drops
  task automatic drain(input string req);
    for (int k = 0; k < WIN; k++) step(1'b0, 1'b0, 1'b1, req);
    step(1'b0, 1'b0, 1'b0, req);
  endtask

  // three-crossing sweep: original polarity o (1 = negative), gaps d1, d2
  task automatic run_seq(input logic o, input int d1, input int d2);
    int t0;
    logic ok, orig, opp, e;
    t0 = d1 + d2;
    ok = (d1 <= WIN) && (d2 <= WIN);
    for (int t = 0; t <= t0 + WIN + 1; t++) begin
      orig = (t == 0) || (t == t0);
      opp  = (t == d1);
      e    = ok && (t >= t0) && (t <= t0 + WIN);
      if (o) step(opp, orig, e, (t < t0) ? "R3" : (t <= t0 + WIN ? "R4" : "R5"));
      else   step(orig, opp, e, (t < t0) ? "R3" : (t <= t0 + WIN ? "R4" : "R5"));
    end
    flush("R3");
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R1");

    // R3/R4/R5/R6: exhaustive gap sweep, both polarities
    for (int o = 0; o < 2; o++)
      for (int d1 = 1; d1 <= WIN + 2; d1++)
        for (int d2 = 1; d2 <= WIN + 2; d2++)
          run_seq(o[0], d1, d2);

    // R2: both flags high at start -> positive is original
    step(1'b1, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b1, "R2");
    drain("R2");
    flush("R2");

    // R5: quiet gaps of 1..WIN inside a packet keep it valid
    step(1'b0, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b1, "R5");
    for (int g = 1; g <= WIN; g++) begin
      for (int k = 0; k < g; k++) step(1'b0, 1'b0, 1'b1, "R5");
      step(g[0], ~g[0], 1'b1, "R5");
    end
    drain("R5");

    // R9: new packet right after end of packet
    step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b1, "R9");
    drain("R9");
    flush("R9");

    // R8: repeated original crossing does not restart the window
    step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    for (int k = 2; k < WIN + 1; k++) step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    flush("R8");

    // R7: flag held across rejection cannot restart an attempt
    for (int k = 0; k <= WIN + 2; k++) step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");
    flush("R7");
    // after release a good sequence qualifies again
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b1, "R7");
    drain("R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule